// File: doc/BRIEF.md
# RAW10 Pixel Packer with Lane Striping

This block turns a stream of 10-bit raw pixels into the compact packed byte stream used by camera serial links, then spreads that byte stream over one, two or four 8-bit output lanes. Every group of four pixels becomes five bytes. The first four bytes are the upper eight bits of each pixel. The fifth byte gathers the two low bits of all four pixels.

Packed bytes are dealt out to the lanes in strict rotation. Group boundaries therefore drift across lane cycles whenever five is not a multiple of the lane count. At the end of a line, a lane cycle that is only partly filled is completed with zero bytes and flagged as the line's final cycle.

Both streaming sides use valid/ready. A pixel is taken on a clock edge where `pix_valid` and `pix_ready` are both high. An output cycle is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the presented lane bytes and marker hold steady. An internal byte queue absorbs the uneven push and pop rates. `pix_ready` drops whenever that queue cannot accept the two bytes a single pixel may produce, so a stalled consumer throttles the source without losing or repeating anything. The lane selection `lane_cfg` is a plain static input.

Top module: `raw10_lane_packer`

## Requirements
- R1: Each four accepted pixels produce exactly five packed bytes, in this order: pixel 0 bits 9:2, pixel 1 bits 9:2, pixel 2 bits 9:2, pixel 3 bits 9:2, then the low-bits byte.
- R2: In the low-bits byte, pixel 0's bits 1:0 sit at byte bits 1:0, pixel 1's at 3:2, pixel 2's at 5:4 and pixel 3's at 7:6.
- R3: With `lane_cfg` = 4, packed byte k leaves on lane (k mod 4). Lane j occupies `out_data[8j+7:8j]`, and each output cycle carries four consecutive bytes.
- R4: With `lane_cfg` = 2, packed byte k leaves on lane (k mod 2), two bytes per cycle. Lanes 2 and 3 are zero.
- R5: With `lane_cfg` = 1, the bytes leave one per cycle on lane 0, in packed order. Lanes 1 to 3 are zero.
- R6: Any `lane_cfg` value other than 1, 2 or 4 behaves exactly like 1.
- R7: `lane_cfg` is taken only at a line start while the block is empty. A change during a line has no effect on that line.
- R8: A line is ended by `pix_last` on its final pixel. Line widths must be a multiple of four, and `pix_last` is ignored unless it falls on the fourth pixel of a group. The final output cycle of the line carries `out_eol` = 1, and its lanes beyond the last packed byte are zero. No earlier cycle has `out_eol` set.
- R9: Under any pattern of stalls on either side, no pixel byte is dropped or duplicated. While `out_valid` is high and `out_ready` is low, `out_data` and `out_eol` stay unchanged.
- R10: A synchronous active-high `rst` empties the block and clears the group and lane phase. Afterwards `out_valid` is 0, `pix_ready` is 1, and the next pixel is pixel 0 of a group placed on lane 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_cfg | input | 3 | Lane count request (1, 2 or 4; other values mean 1) |
| pix_valid | input | 1 | Pixel present |
| pix_ready | output | 1 | Block can take a pixel |
| pix_data | input | 10 | Raw pixel value |
| pix_last | input | 1 | Marks the final pixel of a line |
| out_valid | output | 1 | Lane bytes present |
| out_ready | input | 1 | Consumer takes the lane bytes |
| out_data | output | 32 | Lane j in bits 8j+7:8j |
| out_eol | output | 1 | Final output cycle of a line |

## Verification
The bench sweeps every `lane_cfg` encoding against several line widths, with pixel patterns whose high and low bits are computed arithmetically. It compares every lane cycle against a byte-exact model.

The focus is on the places a wrong design would slip:
- With two lanes, a group boundary can fall mid-cycle. A design that restarts lanes per group would misplace the low-bits byte.
- A line that leaves a partly filled cycle tests padding. A design that pads badly would emit stale bytes there or raise the end marker early.
- A mid-line lane change checks that the selection is held for the whole line. A design that failed here would re-stripe the line.
- Random stalls on both sides expose dropped or repeated bytes.
- A reset in the middle of a group must not leave phase behind in the next line.

// File: rtl/raw10_pkg.sv
package raw10_pkg;
  localparam int PIX_W  = 10;
  localparam int BYTE_W = 8;

  // Map a requested lane count onto 1, 2 or 4; anything else selects one lane.
  function automatic logic [2:0] decode_lanes(input logic [2:0] req);
    case (req)
      3'd2:    decode_lanes = 3'd2;
      3'd4:    decode_lanes = 3'd4;
      default: decode_lanes = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/raw10_group_pack.sv
module raw10_group_pack
  import raw10_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_fire,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              pix_last,
  output logic [1:0]        push_cnt,
  output logic [BYTE_W-1:0] push_b0,
  output logic [BYTE_W-1:0] push_b1,
  output logic              push_l1,
  output logic              at_line_start
);
  logic [1:0] phase;
  logic [5:0] low_acc;   // two low bits of pixels 0..2, pixel 0 ending at [1:0]
  logic       sol_q;

  always_comb begin
    push_b0  = pix_data[PIX_W-1:2];
    push_b1  = {pix_data[1:0], low_acc};
    push_l1  = pix_last;
    push_cnt = !pix_fire ? 2'd0 : (phase == 2'd3) ? 2'd2 : 2'd1;
  end

  assign at_line_start = sol_q && (phase == 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 2'd0;
      low_acc <= '0;
      sol_q   <= 1'b1;
    end else if (pix_fire) begin
      phase   <= phase + 2'd1;
      low_acc <= {pix_data[1:0], low_acc[5:2]};
      sol_q   <= (phase == 2'd3) && pix_last;
    end
  end

  // R1: every accepted pixel advances the group position by one, modulo four
  a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
    pix_fire |=> phase == ($past(phase) + 2'd1));
  // R1: a group-closing pixel is the only one that pushes two bytes
  a_r1_two_on_close: assert property (@(posedge clk) disable iff (rst)
    (push_cnt == 2'd2) |-> (pix_fire && phase == 2'd3));
endmodule

// File: rtl/raw10_byte_queue.sv
module raw10_byte_queue
  import raw10_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int HEAD  = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(HEAD + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             push_cnt,
  input  logic [BYTE_W-1:0]      push_b0,
  input  logic [BYTE_W-1:0]      push_b1,
  input  logic                   push_l1,
  input  logic [PW-1:0]          pop_cnt,
  output logic [HEAD*BYTE_W-1:0] head_data,
  output logic [HEAD-1:0]        head_last,
  output logic [CW-1:0]          count
);
  logic [BYTE_W-1:0] dq [DEPTH];
  logic [BYTE_W-1:0] nd [DEPTH];
  logic [DEPTH-1:0]  lq, nl;
  logic [CW-1:0]     ncount;
  int                rem;

  always_comb begin
    rem = int'(count) - int'(pop_cnt);
    nl  = lq;
    for (int i = 0; i < DEPTH; i++) begin
      nd[i] = dq[i];
      if (i < rem) begin
        if (i + int'(pop_cnt) < DEPTH) begin
          nd[i] = dq[i + int'(pop_cnt)];
          nl[i] = lq[i + int'(pop_cnt)];
        end
      end else if (i == rem && push_cnt != 2'd0) begin
        nd[i] = push_b0;
        nl[i] = 1'b0;
      end else if (i == rem + 1 && push_cnt == 2'd2) begin
        nd[i] = push_b1;
        nl[i] = push_l1;
      end
    end
    ncount = CW'(rem + int'(push_cnt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      lq    <= '0;
    end else begin
      count <= ncount;
      lq    <= nl;
    end
    for (int i = 0; i < DEPTH; i++) dq[i] <= nd[i];
  end

  for (genvar h = 0; h < HEAD; h++) begin : g_head
    assign head_data[h*BYTE_W +: BYTE_W] = dq[h];
    assign head_last[h]                  = lq[h];
  end

  // R9: the queue never holds more than its depth, so no byte is lost
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= DEPTH);
  // R9: the striper never takes bytes that are not there
  a_r9_pop_in_range: assert property (@(posedge clk) disable iff (rst)
    int'(pop_cnt) <= int'(count));
endmodule

// File: rtl/raw10_lane_stripe.sv
module raw10_lane_stripe
  import raw10_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 4,
  localparam int PW   = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2:0]              lane_cfg,
  input  logic                    load_cfg,
  input  logic [LANES*BYTE_W-1:0] head_data,
  input  logic [LANES-1:0]        head_last,
  input  logic [CW-1:0]           count,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [LANES*BYTE_W-1:0] out_data,
  output logic                    out_eol,
  output logic [PW-1:0]           pop_cnt
);
  logic [2:0] lanes_q;
  logic       found;
  int         take;

  always_ff @(posedge clk) begin
    if (rst)           lanes_q <= 3'd1;
    else if (load_cfg) lanes_q <= decode_lanes(lane_cfg);
  end

  always_comb begin
    found = 1'b0;
    take  = 0;
    for (int j = 0; j < LANES; j++) begin
      if (!found && j < int'(lanes_q) && j < int'(count) && head_last[j]) begin
        found = 1'b1;
        take  = j + 1;
      end
    end
    if (!found && int'(count) >= int'(lanes_q)) take = int'(lanes_q);
    out_valid = (take != 0);
    out_eol   = found;
    for (int j = 0; j < LANES; j++)
      out_data[j*BYTE_W +: BYTE_W] = (j < take) ? head_data[j*BYTE_W +: BYTE_W] : '0;
    pop_cnt = (out_valid && out_ready) ? PW'(take) : '0;
  end

  // R9: a stalled output cycle is held unchanged
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eol)));
  // R8: the end marker only rides on a presented cycle
  a_r8_eol_valid: assert property (@(posedge clk) disable iff (rst)
    out_eol |-> out_valid);
  // R6: the working lane count is always exactly one of 1, 2, 4
  a_r6_lanes_legal: assert property (@(posedge clk) disable iff (rst)
    $countones(lanes_q) == 1);
  // R7: the lane count only moves while nothing is in flight
  a_r7_cfg_idle: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> $stable(lanes_q));
endmodule

// File: rtl/raw10_lane_packer.sv
module raw10_lane_packer
  import raw10_pkg::*;
#(
  parameter int QDEPTH = 8,
  localparam int LANES = 4,
  localparam int CW    = $clog2(QDEPTH + 1),
  localparam int PW    = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2:0]              lane_cfg,
  input  logic                    pix_valid,
  output logic                    pix_ready,
  input  logic [PIX_W-1:0]        pix_data,
  input  logic                    pix_last,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*BYTE_W-1:0] out_data,
  output logic                    out_eol
);
  logic [1:0]              push_cnt;
  logic [BYTE_W-1:0]       push_b0, push_b1;
  logic                    push_l1, at_sol, pix_fire;
  logic [LANES*BYTE_W-1:0] head_data;
  logic [LANES-1:0]        head_last;
  logic [CW-1:0]           count;
  logic [PW-1:0]           pop_cnt;

  assign pix_ready = int'(count) <= QDEPTH - 2;
  assign pix_fire  = pix_valid && pix_ready;

  raw10_group_pack u_pack (
    .clk(clk), .rst(rst), .pix_fire(pix_fire), .pix_data(pix_data),
    .pix_last(pix_last), .push_cnt(push_cnt), .push_b0(push_b0),
    .push_b1(push_b1), .push_l1(push_l1), .at_line_start(at_sol)
  );

  raw10_byte_queue #(.DEPTH(QDEPTH), .HEAD(LANES)) u_queue (
    .clk(clk), .rst(rst), .push_cnt(push_cnt), .push_b0(push_b0),
    .push_b1(push_b1), .push_l1(push_l1), .pop_cnt(pop_cnt),
    .head_data(head_data), .head_last(head_last), .count(count)
  );

  raw10_lane_stripe #(.LANES(LANES), .CW(CW)) u_stripe (
    .clk(clk), .rst(rst), .lane_cfg(lane_cfg),
    .load_cfg(at_sol && count == '0), .head_data(head_data),
    .head_last(head_last), .count(count), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_eol(out_eol),
    .pop_cnt(pop_cnt)
  );

  // R10: the cycle after reset is empty and ready
  a_r10_reset_clean: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && pix_ready));
endmodule

// File: tb/raw10_lane_packer_tb_top.sv
module raw10_lane_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  lane_cfg = 3'd1;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [9:0]  pix_data = '0;
  logic        pix_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_eol;

  always #2 clk = ~clk;   // 250 MHz

  raw10_lane_packer dut_i (
    .clk(clk), .rst(rst), .lane_cfg(lane_cfg), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .pix_last(pix_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_eol(out_eol)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int line_w = 0, sent = 0;
  bit feeding = 0, stall_in = 0, stall_out = 0, chg_cfg = 0;
  logic [2:0]  alt_cfg = 3'd1;
  logic [9:0]  px [64];
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] rec_d [$];
  bit          rec_e [$];

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Single driver/monitor: drive at the falling edge, observe after settling.
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual hang expected completion");
      finish_run();
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst) begin
      pix_valid = 0; out_ready = 0; pix_last = 0;
    end else begin
      out_ready = stall_out ? lfsr[0] : 1'b1;
      if (feeding && sent < line_w) begin
        pix_valid = stall_in ? (lfsr[3] | lfsr[7]) : 1'b1;
        pix_data  = px[sent];
        pix_last  = (sent == line_w - 1);
      end else begin
        pix_valid = 0; pix_last = 0;
      end
      if (chg_cfg && sent == 2) lane_cfg = alt_cfg;
    end
    #1;
    if (!rst && out_valid && out_ready) begin
      rec_d.push_back(out_data);
      rec_e.push_back(out_eol);
    end
    if (!rst && pix_valid && pix_ready) sent++;
  end

  function automatic int lanes_of(input logic [2:0] c);
    return (c == 3'd2) ? 2 : (c == 3'd4) ? 4 : 1;
  endfunction

  function automatic logic [9:0] pix_gen(input int seed, input int i);
    case (seed % 4)
      0: return 10'((i * 37 + seed * 113 + 5) & 1023);
      1: return 10'h3FF;
      2: return (i % 2 == 1) ? 10'h2AA : 10'h155;
      default: return 10'(((i % 4) << 8) | ((i * 3 + seed) & 3) | 12'(i << 2));
    endcase
  endfunction

  task automatic run_line(input string tag, input logic [2:0] cfg, input int w,
                          input int seed, input bit si, input bit so,
                          input bit chg, input logic [2:0] alt);
    logic [7:0] b [$];
    int n, nb, ncyc, t;
    logic [31:0] exp;
    lane_cfg = cfg;
    for (int i = 0; i < w; i++) px[i] = pix_gen(seed, i);
    for (int g = 0; g < w / 4; g++) begin
      logic [7:0] s;
      for (int k = 0; k < 4; k++) b.push_back(px[4*g+k][9:2]);
      s = {px[4*g+3][1:0], px[4*g+2][1:0], px[4*g+1][1:0], px[4*g][1:0]};
      b.push_back(s);
    end
    n = lanes_of(cfg); nb = b.size(); ncyc = (nb + n - 1) / n;
    rec_d.delete(); rec_e.delete();
    line_w = w; sent = 0; stall_in = si; stall_out = so;
    chg_cfg = chg; alt_cfg = alt;
    @(posedge clk);
    feeding = 1;
    t = 0;
    while (!(sent == w && rec_d.size() >= ncyc) && t < 3000) begin
      @(posedge clk); t++;
    end
    feeding = 0; chg_cfg = 0;
    repeat (8) @(posedge clk);
    check({tag, " cycle count"}, 32'(rec_d.size()), 32'(ncyc));
    for (int c = 0; c < ncyc && c < rec_d.size(); c++) begin
      exp = '0;
      for (int j = 0; j < n; j++)
        if (c * n + j < nb) exp[j*8 +: 8] = b[c*n+j];
      check({tag, " lane data"}, rec_d[c], exp);
      check({tag, " R8 eol"}, 32'(rec_e[c]), 32'(c == ncyc - 1));
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    rst = 0;
    @(negedge clk); #1;
    check("R10 reset valid", 32'(out_valid), 0);
    check("R10 reset ready", 32'(pix_ready), 1);

    // R1 R2: packing order and low-bit layout on a single lane
    run_line("R1", 3'd1, 8, 0, 0, 0, 0, 3'd1);
    run_line("R2", 3'd1, 12, 3, 0, 0, 0, 3'd1);
    // R3 R4 R5: sweep widths and patterns per lane count
    for (int w = 4; w <= 24; w += 4)
      for (int s = 0; s < 4; s++) begin
        run_line("R3", 3'd4, w, s, 0, 0, 0, 3'd4);
        run_line("R4", 3'd2, w, s, 0, 0, 0, 3'd2);
        run_line("R5", 3'd1, w, s, 0, 0, 0, 3'd1);
      end
    // R6: illegal encodings fall back to one lane
    foreach (px[i]) if (i < 1) ;
    run_line("R6", 3'd0, 8, 0, 0, 0, 0, 3'd0);
    run_line("R6", 3'd3, 8, 1, 0, 0, 0, 3'd3);
    run_line("R6", 3'd5, 12, 2, 0, 0, 0, 3'd5);
    run_line("R6", 3'd6, 4, 3, 0, 0, 0, 3'd6);
    run_line("R6", 3'd7, 16, 0, 0, 0, 0, 3'd7);
    // R7: mid-line changes are ignored for that line
    run_line("R7", 3'd4, 16, 0, 0, 0, 1, 3'd1);
    run_line("R7", 3'd2, 20, 2, 0, 0, 1, 3'd4);
    run_line("R7", 3'd1, 12, 1, 0, 0, 1, 3'd2);
    // R8: widths leaving a partly filled last cycle
    run_line("R8", 3'd4, 4, 0, 0, 0, 0, 3'd4);
    run_line("R8", 3'd2, 4, 2, 0, 0, 0, 3'd2);
    run_line("R8", 3'd4, 20, 1, 0, 0, 0, 3'd4);
    // R9: stalls on either or both sides
    for (int c = 0; c < 3; c++)
      for (int s = 0; s < 3; s++) begin
        logic [2:0] cf;
        cf = (c == 0) ? 3'd1 : (c == 1) ? 3'd2 : 3'd4;
        run_line("R9", cf, 24, s, 1, 0, 0, cf);
        run_line("R9", cf, 24, s, 0, 1, 0, cf);
        run_line("R9", cf, 24, s, 1, 1, 0, cf);
      end
    // R10: reset in the middle of a group, then a clean line
    lane_cfg = 3'd4;
    for (int i = 0; i < 8; i++) px[i] = 10'h3FF;
    line_w = 8; sent = 0; stall_in = 0; stall_out = 1;
    feeding = 1;
    while (sent < 3) @(posedge clk);
    feeding = 0;
    rst = 1;
    repeat (2) @(posedge clk);
    rst = 0;
    @(negedge clk); #1;
    check("R10 mid-line reset valid", 32'(out_valid), 0);
    check("R10 mid-line reset ready", 32'(pix_ready), 1);
    run_line("R10", 3'd4, 8, 0, 0, 0, 0, 3'd4);
    run_line("R10", 3'd2, 12, 3, 1, 1, 0, 3'd2);
    finish_run();
  end
endmodule